// File: doc/BRIEF.md
# Request/Grant Bus Hand-off Controller

This block sits on the owning side of a shared local bus and lets other masters borrow it. Each borrowing master reaches the block through its own open-drain, active-low line, and every exchange on a line takes three pulses, each one clock wide. The borrower pulses low to ask for the bus. The block pulls the same line low for one clock to grant it. The borrower pulses low again when it is done. While the bus is lent out, the block raises a float output so the bus sequencer tri-states its drivers.

The sequencer reports which bus phase each clock belongs to, along with three flags that can block a hand-off. The block uses these to choose the clock in which it grants. A pending request is held until that clock arrives. When requests arrive together, the lowest-numbered line wins. Requests that come in while an exchange is already in progress are dropped. One clock after the release, the block takes the bus back. That clock is a dead clock in which no new request is accepted.

Top module: `rg_handoff`

## Requirements
- R1: While reset is high and in the first clock after it, every `rg_pull_o` bit is 0 and `bus_float_o` is 0.
- R2: Take an idle bus (phase code 0) and a line that is sampled low in clock t while the block is not driving it. The block then drives that same line (its `rg_pull_o` bit at 1) for exactly one clock, clock t+2, provided clock t+1 is also idle.
- R3: `bus_float_o` goes to 1 in the grant clock and stays at 1 until a separate low pulse arrives on the granted line. It is 0 in the clock after that release pulse. The block's own grant drive never counts as the release.
- R4: After a release, the next clock is dead. A request pulse in that clock is ignored. A request pulse one clock later is accepted.
- R5: When both lines pulse low in the same clock on an idle bus, line 0 receives the grant and the request on line 1 is dropped.
- R6: Phase codes are idle=0, T1=1, T2=2, T3=3, T4=4, wait=5. A grant is driven only in the clock that follows a T4 clock or an idle clock. A request taken in T1 or T2 of a memory cycle is granted in the clock after that cycle's T4.
- R7: A request that arrives in T3 or in a wait clock is not granted after the current T4. It is held, and it is granted after the T4 of the next cycle, once that cycle has passed T1 or T2.
- R8: If `split_low_i` is 1 during T4, no grant follows. The request is held and is served after a later T4 at which all blocking flags are 0.
- R9: If `first_ack_i` is 1 during T4, no grant follows. The request is held in the same way.
- R10: If `locked_i` is 1 during T4, no grant follows. The request is held in the same way.
- R11: A low pulse on the other line while a request is pending or the bus is lent out is ignored. It leaves `bus_float_o` unchanged and never leads to a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Bus phase of the current clock (0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait) |
| split_low_i | input | 1 | Current cycle is the first half of a word split across an odd address |
| first_ack_i | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| locked_i | input | 1 | A locked instruction is executing |
| rg_line_i | input | NCH | Sampled level of each request/grant line (0 = pulled low) |
| rg_pull_o | output | NCH | Pull-down enable for each line (1 = drive low) |
| bus_float_o | output | 1 | Tri-state request for the local bus drivers |

## Verification
Several things can land in the same clock and must not be confused. The end of one exchange can coincide with the start of the next. A grant can coincide with a request from the other master. The bench drives a release pulse and then a new request in the dead clock that follows. It also drives a request in the clock after that. Only the second request may produce a grant, and the scoreboard checks its exact clock. A second case pulses both lines together, and others pulse the second line during a pending or lent-out exchange. Here the bench checks that the float output is steady and that no unlisted grant ever appears.

// File: rtl/rg_handoff_pkg.sv
package rg_handoff_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4,
        PH_TW   = 3'd5
    } bus_phase_e;

    typedef enum logic [2:0] {
        HS_OWN   = 3'd0,
        HS_PEND  = 3'd1,
        HS_GRANT = 3'd2,
        HS_HOLD  = 3'd3,
        HS_DEAD  = 3'd4
    } hs_state_e;

    typedef struct packed {
        logic split_low;
        logic first_ack;
        logic locked;
    } cyc_cond_t;

    // Phases in which a request still counts as early enough for this cycle.
    function automatic logic phase_is_early(bus_phase_e p);
        return (p == PH_T1) || (p == PH_T2);
    endfunction

    function automatic logic conds_clear(cyc_cond_t c);
        return !(c.split_low || c.first_ack || c.locked);
    endfunction

endpackage

// File: rtl/rg_line_sense.sv
module rg_line_sense #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] line_i,
    input  logic [NCH-1:0] pull_i,
    output logic [NCH-1:0] low_seen_o
);
    // A line only counts as pulled by someone else when this side is not
    // driving it itself.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign low_seen_o[g] = !line_i[g] && !pull_i[g];
    end
endmodule

// File: rtl/rg_prio_pick.sv
module rg_prio_pick #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic [NCH-1:0] req_i,
    output logic           any_o,
    output logic [CHW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        // Walk from the top down so the lowest index is assigned last and wins.
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = CHW'(i);
        end
    end
endmodule

// File: rtl/rg_release_qual.sv
module rg_release_qual
    import rg_handoff_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_phase_e phase_i,
    input  cyc_cond_t  cond_i,
    input  logic       arm_i,
    input  logic       pending_i,
    output logic       eligible_o
);
    logic early_q;

    // early_q: the held request has been seen in T1/T2 of the current cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= 1'b0;
        end else if (arm_i) begin
            early_q <= phase_is_early(phase_i);
        end else if (pending_i) begin
            if (phase_is_early(phase_i)) begin
                early_q <= 1'b1;
            end else if (phase_i == PH_T4) begin
                early_q <= 1'b0;
            end
        end else begin
            early_q <= 1'b0;
        end
    end

    always_comb begin
        eligible_o = 1'b0;
        if (pending_i) begin
            if (phase_i == PH_IDLE) begin
                eligible_o = 1'b1;
            end else if (phase_i == PH_T4 && early_q && conds_clear(cond_i)) begin
                eligible_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rg_handoff_fsm.sv
module rg_handoff_fsm
    import rg_handoff_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] low_seen_i,
    input  logic           pick_any_i,
    input  logic [CHW-1:0] pick_idx_i,
    input  logic           eligible_i,
    output logic           arm_o,
    output logic           pending_o,
    output logic [NCH-1:0] pull_o,
    output logic           bus_float_o
);
    hs_state_e      state_q, state_d;
    logic [CHW-1:0] ch_q, ch_d;
    logic           release_seen;

    assign release_seen = low_seen_i[ch_q];
    assign arm_o        = (state_q == HS_OWN) && pick_any_i;
    assign pending_o    = (state_q == HS_PEND);

    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        case (state_q)
            HS_OWN: begin
                if (pick_any_i) begin
                    state_d = HS_PEND;
                    ch_d    = pick_idx_i;
                end
            end
            HS_PEND:  if (eligible_i)   state_d = HS_GRANT;
            HS_GRANT:                   state_d = HS_HOLD;
            HS_HOLD:  if (release_seen) state_d = HS_DEAD;
            HS_DEAD:                    state_d = HS_OWN;
            default:                    state_d = HS_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_OWN;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_pull
        assign pull_o[g] = (state_q == HS_GRANT) && (ch_q == CHW'(g));
    end

    assign bus_float_o = (state_q == HS_GRANT) || (state_q == HS_HOLD);
endmodule

// File: rtl/rg_handoff.sv
module rg_handoff
    import rg_handoff_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     phase_i,
    input  logic           split_low_i,
    input  logic           first_ack_i,
    input  logic           locked_i,
    input  logic [NCH-1:0] rg_line_i,
    output logic [NCH-1:0] rg_pull_o,
    output logic           bus_float_o
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    bus_phase_e     phase;
    cyc_cond_t      cond;
    logic [NCH-1:0] low_seen;
    logic           pick_any;
    logic [CHW-1:0] pick_idx;
    logic           eligible;
    logic           arm;
    logic           pending;

    assign phase = bus_phase_e'(phase_i);
    assign cond  = '{split_low: split_low_i, first_ack: first_ack_i, locked: locked_i};

    rg_line_sense #(.NCH(NCH)) u_sense (
        .line_i     (rg_line_i),
        .pull_i     (rg_pull_o),
        .low_seen_o (low_seen)
    );

    rg_prio_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req_i (low_seen),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    rg_release_qual u_qual (
        .clk        (clk),
        .rst        (rst),
        .phase_i    (phase),
        .cond_i     (cond),
        .arm_i      (arm),
        .pending_i  (pending),
        .eligible_o (eligible)
    );

    rg_handoff_fsm #(.NCH(NCH), .CHW(CHW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .low_seen_i  (low_seen),
        .pick_any_i  (pick_any),
        .pick_idx_i  (pick_idx),
        .eligible_i  (eligible),
        .arm_o       (arm),
        .pending_o   (pending),
        .pull_o      (rg_pull_o),
        .bus_float_o (bus_float_o)
    );
endmodule

// File: rtl/rg_handoff_chk.sv
module rg_handoff_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [2:0]     phase_i,
    input logic           split_low_i,
    input logic           first_ack_i,
    input logic           locked_i,
    input logic [NCH-1:0] rg_pull_o,
    input logic           bus_float_o
);
    localparam logic [2:0] C_IDLE = 3'd0;
    localparam logic [2:0] C_T3   = 3'd3;
    localparam logic [2:0] C_T4   = 3'd4;
    localparam logic [2:0] C_TW   = 3'd5;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (rg_pull_o == '0 && !bus_float_o));

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rg_pull_o));

    assert_grant_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
        (|rg_pull_o) |=> (rg_pull_o == '0));

    assert_float_in_grant_R3: assert property (@(posedge clk) disable iff (rst)
        (|rg_pull_o) |-> bus_float_o);

    assert_float_after_grant_R3: assert property (@(posedge clk) disable iff (rst)
        (|rg_pull_o) |=> bus_float_o);

    assert_grant_slot_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(|rg_pull_o) |-> ($past(phase_i) == C_T4 || $past(phase_i) == C_IDLE));

    assert_late_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_i == C_T3 || phase_i == C_TW) |=> (rg_pull_o == '0));

    assert_split_block_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_i == C_T4 && split_low_i) |=> (rg_pull_o == '0));

    assert_ack_block_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_i == C_T4 && first_ack_i) |=> (rg_pull_o == '0));

    assert_lock_block_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_i == C_T4 && locked_i) |=> (rg_pull_o == '0));
endmodule

bind rg_handoff rg_handoff_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase_i),
    .split_low_i (split_low_i),
    .first_ack_i (first_ack_i),
    .locked_i    (locked_i),
    .rg_pull_o   (rg_pull_o),
    .bus_float_o (bus_float_o)
);

// File: tb/rg_handoff_test.sv
module rg_handoff_test;
    localparam int NCH = 2;

    typedef struct {
        int    slot;
        int    ch;
        string tag;
    } grant_item_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     phase = 3'd0;
    logic [2:0]     conds = 3'b000;
    logic [NCH-1:0] ext_low = '0;
    logic [NCH-1:0] rg_line;
    logic [NCH-1:0] rg_pull;
    logic           bus_float;

    int checks = 0;
    int failures = 0;
    int dslot = 0;
    int mslot = 0;
    bit done = 1'b0;
    string cur_tag = "R1";
    grant_item_t exp_q[$];

    always #4 clk = ~clk;

    // Open-drain line with pull-up: low if either side pulls it.
    assign rg_line = ~(rg_pull | ext_low);

    rg_handoff #(.NCH(NCH)) uut (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase),
        .split_low_i (conds[2]),
        .first_ack_i (conds[1]),
        .locked_i    (conds[0]),
        .rg_line_i   (rg_line),
        .rg_pull_o   (rg_pull),
        .bus_float_o (bus_float)
    );

    // Monitor: compares observed grant pulses against the expectation queue.
    always @(negedge clk) begin
        mslot = mslot + 1;
        if (!rst) begin
            if (rg_pull != '0) begin
                checks++;
                if (exp_q.size() == 0 || exp_q[0].slot != mslot) begin
                    failures++;
                    $display("FAIL %s unexpected grant slot=%0d actual=%b expected=00",
                             cur_tag, mslot, rg_pull);
                end else begin
                    if (rg_pull != (NCH'(1) << exp_q[0].ch)) begin
                        failures++;
                        $display("FAIL %s grant slot=%0d actual=%b expected=%b",
                                 exp_q[0].tag, mslot, rg_pull, NCH'(1) << exp_q[0].ch);
                    end
                    void'(exp_q.pop_front());
                end
            end else if (exp_q.size() != 0 && exp_q[0].slot == mslot) begin
                checks++;
                failures++;
                $display("FAIL %s missing grant slot=%0d actual=%b expected=%b",
                         exp_q[0].tag, mslot, rg_pull, NCH'(1) << exp_q[0].ch);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic drive(input logic [2:0] p, input logic [NCH-1:0] e, input logic [2:0] c);
        @(negedge clk);
        dslot = dslot + 1;
        phase   = p;
        ext_low = e;
        conds   = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(3'd0, '0, 3'b000);
    endtask

    task automatic expect_grant(input int ch, input int delta, input string tag);
        grant_item_t it;
        it.slot = dslot + delta;
        it.ch   = ch;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic check_float(input logic expv, input string tag);
        checks++;
        if (bus_float !== expv) begin
            failures++;
            $display("FAIL %s bus_float slot=%0d actual=%b expected=%b",
                     tag, dslot, bus_float, expv);
        end
    endtask

    // Release pulse on a line, then check the bus is reclaimed next clock.
    task automatic release_line(input int ch, input string tag);
        drive(3'd0, NCH'(1) << ch, 3'b000);
        check_float(1'b1, tag);
        drive(3'd0, '0, 3'b000);
        check_float(1'b0, tag);
        idle(2);
    endtask

    initial begin
        // R1: reset state
        idle(4);
        checks++;
        if (rg_pull !== '0 || bus_float !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset pull=%b float=%b expected pull=00 float=0", rg_pull, bus_float);
        end
        rst = 1'b0;
        idle(1);
        check_float(1'b0, "R1");
        idle(2);

        // R2/R3: idle request on line 0
        cur_tag = "R2";
        drive(3'd0, 2'b01, 3'b000);
        expect_grant(0, 2, "R2");
        idle(2);
        check_float(1'b1, "R3");
        idle(1);
        check_float(1'b1, "R3");
        idle(3);
        check_float(1'b1, "R3");

        // R4: release, request in dead clock ignored, next clock accepted
        cur_tag = "R4";
        drive(3'd0, 2'b01, 3'b000);
        drive(3'd0, 2'b10, 3'b000);
        check_float(1'b0, "R3");
        drive(3'd0, 2'b10, 3'b000);
        expect_grant(1, 2, "R4");
        idle(3);
        check_float(1'b1, "R4");
        release_line(1, "R4");
        idle(3);

        // R5/R11: simultaneous requests, then line 1 pulses while lent out
        cur_tag = "R5";
        drive(3'd0, 2'b11, 3'b000);
        expect_grant(0, 2, "R5");
        idle(3);
        cur_tag = "R11";
        drive(3'd0, 2'b10, 3'b000);
        idle(1);
        check_float(1'b1, "R11");
        release_line(0, "R5");
        idle(4);

        // R6: request in T1 of a memory cycle, line 1 pulses while pending
        cur_tag = "R6";
        drive(3'd1, 2'b01, 3'b000);
        drive(3'd2, 2'b10, 3'b000);
        drive(3'd3, '0, 3'b000);
        drive(3'd4, '0, 3'b000);
        expect_grant(0, 1, "R6");
        idle(2);
        check_float(1'b1, "R6");
        release_line(0, "R6");

        // R7: request in T3 waits for the next cycle
        cur_tag = "R7";
        drive(3'd3, 2'b10, 3'b000);
        drive(3'd4, '0, 3'b000);
        drive(3'd1, '0, 3'b000);
        drive(3'd2, '0, 3'b000);
        drive(3'd3, '0, 3'b000);
        drive(3'd4, '0, 3'b000);
        expect_grant(1, 1, "R7");
        idle(2);
        release_line(1, "R7");

        // R7: request in a wait clock
        drive(3'd5, 2'b01, 3'b000);
        drive(3'd5, '0, 3'b000);
        drive(3'd4, '0, 3'b000);
        drive(3'd1, '0, 3'b000);
        drive(3'd2, '0, 3'b000);
        drive(3'd3, '0, 3'b000);
        drive(3'd4, '0, 3'b000);
        expect_grant(0, 1, "R7");
        idle(2);
        release_line(0, "R7");

        // R8/R9/R10: each blocking flag at T4 defers the grant by one cycle
        for (int k = 0; k < 3; k++) begin
            logic [2:0] blk;
            string      tg;
            blk = 3'b100 >> k;
            tg  = (k == 0) ? "R8" : (k == 1) ? "R9" : "R10";
            cur_tag = tg;
            drive(3'd1, 2'b10, 3'b000);
            drive(3'd2, '0, 3'b000);
            drive(3'd3, '0, 3'b000);
            drive(3'd4, '0, blk);
            drive(3'd1, '0, 3'b000);
            check_float(1'b0, tg);
            drive(3'd2, '0, 3'b000);
            drive(3'd3, '0, 3'b000);
            drive(3'd4, '0, 3'b000);
            expect_grant(1, 1, tg);
            idle(2);
            release_line(1, tg);
        end

        idle(6);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL %s grants never seen actual=%0d expected=0", exp_q[0].tag, exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule